// File: doc/BRIEF.md
# Interrupt Destination Resolver with Rotation

This block takes one interrupt message at a time and turns its destination fields into a bitmask over `N_PROC` processors. The mask has one bit for each processor that should receive the message. It then hands the mask on to a dispatcher, together with an unchanged copy of the message.

The destination mode bit selects how the destination byte is read:

- **Physical mode.** The byte is a processor number, or the value 0xFF, which means all processors.
- **Logical mode.** Each processor supplies its own 8-bit logical-destination byte. A processor is a target when that byte shares at least one set bit with the message's destination byte.

For lowest-priority delivery in logical mode, processor priorities are not compared. The block keeps a free-running rotation offset. It picks the match whose rank, counting matches from the lowest processor number, equals the offset modulo the number of matches. The modulo is found by repeated subtraction, one step per cycle, so the input is not ready while the block works.

Lowest-priority delivery in physical mode is an illegal request. It raises a one-cycle error and produces no output.

Top module: `irq_dest_resolver`

## Requirements
- R1: After reset, `out_valid` and `out_err` are 0, `in_ready` is 1, and the rotation offset is 0.
- R2: With `in_dest_mode`=0 and `in_dest`=0xFF, `out_mask` has every bit set.
- R3: With `in_dest_mode`=0 and any other `in_dest`, `out_mask` has only bit `in_dest` set. The mask is all zero when `in_dest` >= `N_PROC`.
- R4: With `in_dest_mode`=0 and `in_deliv`=3'b001 (lowest priority), the cycle after acceptance pulses `out_err` for one cycle. No `out_valid` follows.
- R5: With `in_dest_mode`=1 and any `in_deliv` other than 3'b001, bit i of `out_mask` is set exactly when (`in_ldest[8*i+7:8*i]` & `in_dest`) != 0.
- R6: With `in_dest_mode`=1 and `in_deliv`=3'b001, when m matches exist (m>0), `out_mask` is one-hot. Its bit is the match of rank (offset mod m), with rank 0 being the lowest-numbered matching processor.
- R7: The offset rises by one for each lowest-priority selection (R6). It wraps modulo 2^`ROT_W` and is never cleared between messages.
- R8: A logical lowest-priority message with no match yields an all-zero `out_mask` with `out_valid` asserted. The offset is left unchanged.
- R9: `out_valid` stays high, with mask and fields stable, until `out_ready` is high. `in_ready` is low from acceptance until the output is taken.
- R10: `out_dest`, `out_dest_mode`, `out_deliv`, `out_vector`, `out_trigger` and `out_level` equal the fields of the accepted message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Message offered |
| in_ready | output | 1 | Block can accept a message |
| in_dest | input | 8 | Destination byte |
| in_dest_mode | input | 1 | 0 physical, 1 logical |
| in_deliv | input | 3 | Delivery mode, 3'b001 lowest priority |
| in_vector | input | 8 | Interrupt vector |
| in_trigger | input | 1 | Trigger mode |
| in_level | input | 1 | Level/polarity |
| in_ldest | input | 8*N_PROC | Logical-destination byte of each processor |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Dispatcher takes the result |
| out_mask | output | N_PROC | Target processors |
| out_dest | output | 8 | Forwarded destination |
| out_dest_mode | output | 1 | Forwarded destination mode |
| out_deliv | output | 3 | Forwarded delivery mode |
| out_vector | output | 8 | Forwarded vector |
| out_trigger | output | 1 | Forwarded trigger |
| out_level | output | 1 | Forwarded level |
| out_err | output | 1 | One-cycle pulse for an illegal physical lowest-priority request |

## Verification
The following are checked by assertions on every cycle:

- The output is held stable under backpressure, and `in_ready` is low while a result is pending.
- An error pulse never coincides with a valid output.
- A broadcast always yields a full mask.
- A lowest-priority logical result never has more than one bit set.
- The offset moves by exactly one on each selection and stays put otherwise.

Which match gets chosen for a given offset, the wrap of the offset after 2^`ROT_W` selections, the empty-match pass-through, and the exact error timing are shown only by the bench's directed scenarios. The bench compares each of these against its own model of the rotation.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam logic [2:0] DELIV_LOWEST = 3'b001;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROT  = 2'd1,
    ST_OUT  = 2'd2
  } resolve_state_t;

  typedef struct packed {
    logic [7:0] dest;
    logic       dest_mode;
    logic [2:0] deliv;
    logic [7:0] vector;
    logic       trigger;
    logic       level;
  } irq_msg_t;
endpackage

// File: rtl/irq_phys_decode.sv
module irq_phys_decode #(
  parameter int N_PROC = 8
) (
  input  logic [7:0]        dest,
  output logic [N_PROC-1:0] mask
);
  localparam logic [7:0] BCAST = 8'hFF;

  for (genvar i = 0; i < N_PROC; i++) begin : g_id
    assign mask[i] = (dest == BCAST) || (dest == 8'(i));
  end
endmodule

// File: rtl/irq_logic_match.sv
module irq_logic_match #(
  parameter int N_PROC = 8
) (
  input  logic [7:0]          dest,
  input  logic [8*N_PROC-1:0] ldest,
  output logic [N_PROC-1:0]   mask
);
  for (genvar i = 0; i < N_PROC; i++) begin : g_match
    assign mask[i] = |(ldest[8*i +: 8] & dest);
  end
endmodule

// File: rtl/irq_rotate_pick.sv
module irq_rotate_pick #(
  parameter int N_PROC = 8,
  parameter int ROT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N_PROC-1:0] match_in,
  output logic              done,
  output logic [N_PROC-1:0] pick
);
  localparam int CNT_W = $clog2(N_PROC + 1);

  function automatic logic [CNT_W-1:0] count_ones(input logic [N_PROC-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < N_PROC; i++) c = c + CNT_W'(m[i]);
    return c;
  endfunction

  function automatic logic [N_PROC-1:0] nth_set(input logic [N_PROC-1:0] m,
                                                input logic [ROT_W-1:0] k);
    logic [N_PROC-1:0] r;
    int seen;
    r = '0;
    seen = 0;
    for (int i = 0; i < N_PROC; i++) begin
      if (m[i]) begin
        if (seen == int'(k)) r[i] = 1'b1;
        seen++;
      end
    end
    return r;
  endfunction

  logic              active;
  logic [ROT_W-1:0]  rem;
  logic [ROT_W-1:0]  divisor;
  logic [ROT_W-1:0]  offset;
  logic [N_PROC-1:0] set_q;
  logic              sel_event;

  assign done      = active && (rem < divisor);
  assign sel_event = done;
  assign pick      = nth_set(set_q, rem);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      rem     <= '0;
      divisor <= '0;
      offset  <= '0;
      set_q   <= '0;
    end else if (start) begin
      active  <= 1'b1;
      rem     <= offset;
      divisor <= ROT_W'(count_ones(match_in));
      set_q   <= match_in;
    end else if (active) begin
      if (rem >= divisor) begin
        rem <= rem - divisor;
      end else begin
        active <= 1'b0;
        offset <= offset + 1'b1;
      end
    end
  end

  p_offset_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_event |=> offset == $past(offset) + 1'b1);
  p_offset_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_event |=> $stable(offset));
  p_pick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones(pick) == 1);
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_route_pkg::*;
#(
  parameter int N_PROC = 8,
  parameter int ROT_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [7:0]          in_dest,
  input  logic                in_dest_mode,
  input  logic [2:0]          in_deliv,
  input  logic [7:0]          in_vector,
  input  logic                in_trigger,
  input  logic                in_level,
  input  logic [8*N_PROC-1:0] in_ldest,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [N_PROC-1:0]   out_mask,
  output logic [7:0]          out_dest,
  output logic                out_dest_mode,
  output logic [2:0]          out_deliv,
  output logic [7:0]          out_vector,
  output logic                out_trigger,
  output logic                out_level,
  output logic                out_err
);
  resolve_state_t    state;
  irq_msg_t          msg_q;
  logic [N_PROC-1:0] mask_q;
  logic              err_q;

  logic [N_PROC-1:0] phys_mask;
  logic [N_PROC-1:0] log_mask;
  logic [N_PROC-1:0] pick_mask;
  logic              pick_done;
  logic              accept;
  logic              in_lp;
  logic              rot_start;
  logic              illegal_req;

  irq_phys_decode #(.N_PROC(N_PROC)) u_phys (
    .dest (in_dest),
    .mask (phys_mask)
  );

  irq_logic_match #(.N_PROC(N_PROC)) u_logic (
    .dest  (in_dest),
    .ldest (in_ldest),
    .mask  (log_mask)
  );

  irq_rotate_pick #(.N_PROC(N_PROC), .ROT_W(ROT_W)) u_rot (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (rot_start),
    .match_in (log_mask),
    .done     (pick_done),
    .pick     (pick_mask)
  );

  assign in_ready    = (state == ST_IDLE);
  assign accept      = in_valid && in_ready;
  assign in_lp       = (in_deliv == DELIV_LOWEST);
  assign illegal_req = accept && !in_dest_mode && in_lp;
  assign rot_start   = accept && in_dest_mode && in_lp && (|log_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      msg_q  <= '0;
      mask_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            msg_q <= '{dest: in_dest, dest_mode: in_dest_mode, deliv: in_deliv,
                       vector: in_vector, trigger: in_trigger, level: in_level};
            if (illegal_req) begin
              err_q <= 1'b1;
            end else if (rot_start) begin
              state <= ST_ROT;
            end else begin
              mask_q <= in_dest_mode ? log_mask : phys_mask;
              state  <= ST_OUT;
            end
          end
        end
        ST_ROT: begin
          if (pick_done) begin
            mask_q <= pick_mask;
            state  <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (out_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign out_valid     = (state == ST_OUT);
  assign out_mask      = mask_q;
  assign out_dest      = msg_q.dest;
  assign out_dest_mode = msg_q.dest_mode;
  assign out_deliv     = msg_q.deliv;
  assign out_vector    = msg_q.vector;
  assign out_trigger   = msg_q.trigger;
  assign out_level     = msg_q.level;
  assign out_err       = err_q;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mask) && $stable(out_vector));
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  p_err_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> !out_valid);
  p_err_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |=> !out_err);
  p_bcast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_dest_mode && out_dest == 8'hFF |-> &out_mask);
  p_lp_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dest_mode && out_deliv == DELIV_LOWEST |-> $countones(out_mask) <= 1);
endmodule

// File: tb/irq_dest_resolver_test.sv
module irq_dest_resolver_test;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [7:0]     in_dest = '0;
  logic           in_dest_mode = 1'b0;
  logic [2:0]     in_deliv = '0;
  logic [7:0]     in_vector = '0;
  logic           in_trigger = 1'b0;
  logic           in_level = 1'b0;
  logic [7:0]     ld [N];
  logic [8*N-1:0] in_ldest;
  logic           out_valid;
  logic           out_ready = 1'b0;
  logic [N-1:0]   out_mask;
  logic [7:0]     out_dest;
  logic           out_dest_mode;
  logic [2:0]     out_deliv;
  logic [7:0]     out_vector;
  logic           out_trigger;
  logic           out_level;
  logic           out_err;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_off = '0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) in_ldest[8*i +: 8] = ld[i];
  end

  irq_dest_resolver #(.N_PROC(N), .ROT_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dest(in_dest), .in_dest_mode(in_dest_mode), .in_deliv(in_deliv),
    .in_vector(in_vector), .in_trigger(in_trigger), .in_level(in_level),
    .in_ldest(in_ldest), .out_valid(out_valid), .out_ready(out_ready),
    .out_mask(out_mask), .out_dest(out_dest), .out_dest_mode(out_dest_mode),
    .out_deliv(out_deliv), .out_vector(out_vector), .out_trigger(out_trigger),
    .out_level(out_level), .out_err(out_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic offer(input logic [7:0] d, input logic dm, input logic [2:0] dv,
                       input logic [7:0] vec);
    @(negedge clk);
    in_dest = d; in_dest_mode = dm; in_deliv = dv; in_vector = vec;
    in_trigger = vec[0]; in_level = vec[1]; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_out();
    int n;
    n = 0;
    while (!out_valid && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic take();
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  function automatic logic [N-1:0] model_logic(input logic [7:0] d);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (ld[i] & d) != 8'h00;
    return m;
  endfunction

  function automatic logic [N-1:0] model_lp(input logic [7:0] d, input logic [7:0] off);
    int idx [N];
    int cnt;
    logic [N-1:0] m;
    cnt = 0;
    m = '0;
    for (int i = 0; i < N; i++) if ((ld[i] & d) != 0) begin idx[cnt] = i; cnt++; end
    if (cnt > 0) m[idx[int'(off) % cnt]] = 1'b1;
    return m;
  endfunction

  task automatic t_reset();
    check("R1 valid", 32'(out_valid), 0);
    check("R1 err", 32'(out_err), 0);
    check("R1 ready", 32'(in_ready), 1);
  endtask

  task automatic t_phys(input logic [7:0] d, input logic [N-1:0] exp, input string req);
    offer(d, 1'b0, 3'b000, 8'h5A);
    wait_out();
    check(req, 32'(out_valid), 1);
    check(req, 32'(out_mask), 32'(exp));
    take();
  endtask

  task automatic t_illegal();
    offer(8'h02, 1'b0, 3'b001, 8'h33);
    check("R4 err pulse", 32'(out_err), 1);
    check("R4 no valid", 32'(out_valid), 0);
    @(negedge clk);
    check("R4 err one cycle", 32'(out_err), 0);
    repeat (3) @(negedge clk);
    check("R4 still no valid", 32'(out_valid), 0);
  endtask

  task automatic t_logic(input logic [7:0] d);
    offer(d, 1'b1, 3'b000, 8'hC6);
    wait_out();
    check("R5 logical mask", 32'(out_mask), 32'(model_logic(d)));
    check("R10 vector", 32'(out_vector), 32'hC6);
    check("R10 dest", 32'(out_dest), 32'(d));
    check("R10 fields", {28'd0, out_dest_mode, out_deliv}, {28'd0, 1'b1, 3'b000});
    check("R10 trig/level", {30'd0, out_level, out_trigger}, {30'd0, 1'b1, 1'b0});
    take();
  endtask

  task automatic t_lp(input logic [7:0] d, input string req);
    offer(d, 1'b1, 3'b001, 8'h41);
    wait_out();
    check(req, 32'(out_valid), 1);
    check(req, 32'(out_mask), 32'(model_lp(d, exp_off)));
    if (model_logic(d) != '0) exp_off = exp_off + 1'b1;
    take();
  endtask

  task automatic t_backpressure();
    logic [N-1:0] first;
    offer(8'hFF, 1'b0, 3'b000, 8'h77);
    wait_out();
    first = out_mask;
    repeat (4) @(negedge clk);
    check("R9 held valid", 32'(out_valid), 1);
    check("R9 held mask", 32'(out_mask), 32'(first));
    check("R9 not ready", 32'(in_ready), 0);
    take();
    check("R9 released", 32'(out_valid), 0);
    check("R9 ready again", 32'(in_ready), 1);
  endtask

  initial begin
    for (int i = 0; i < N; i++) ld[i] = 8'(1 << i);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_phys(8'hFF, 8'hFF, "R2 broadcast");
    t_phys(8'h03, 8'h08, "R3 id 3");
    t_phys(8'h00, 8'h01, "R3 id 0");
    t_phys(8'h14, 8'h00, "R3 id out of range");
    t_illegal();
    t_logic(8'h0F);
    for (int i = 0; i < N; i++) ld[i] = 8'(i);
    t_logic(8'h03);
    for (int i = 0; i < N; i++) ld[i] = 8'(1 << i);
    for (int k = 0; k < 5; k++) t_lp(8'h29, "R6 rotation");
    t_lp(8'h00, "R8 empty match");
    t_lp(8'h29, "R8 offset unchanged");
    t_backpressure();
    for (int k = 0; k < 260; k++) t_lp(8'h29, "R7 offset wrap");
    t_lp(8'hE0, "R7 after wrap");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule